// File: doc/BRIEF.md
# Pipeline Interlock and Forwarding Control

This block is the hazard logic for a single-issue, in-order integer pipeline with five stages. It has no state. It looks at the instruction in decode: its opcode class and its two source register fields. It also looks at the three older instructions in execute, memory and writeback: their opcode classes and their rt and rd fields. From these it works out which register each older instruction writes, and whether it writes one at all. It also works out which sources the decode instruction really reads. The results are a decode-stage stall and a forwarding select for each of the two ALU operands.

A two-bit mode input chooses one of three datapath builds:
- an interlock-only pipeline with no forwarding paths;
- a pipeline with one path from the execute-stage ALU result to operand A;
- a fully forwarded pipeline, where only a load result still in execute forces a wait.

In all three modes a taken conditional branch in execute makes the decode instruction invalid, so the stall is withheld.

Top module: `hazard_ctrl`

## Requirements
- R1: Opcode class codes are NOP=0, ALU=1, ALUI=2, LOAD=3, STORE=4, BEQZ=5, BNEZ=6, J=7, JAL=8, JR=9, JALR=10, and codes 11 to 15 behave as NOP. For each older stage the written register and its enable follow these rules:
  - ALU writes rd.
  - ALUI and LOAD write rt.
  - For ALU, ALUI and LOAD the enable is on only when that register is not 0.
  - JAL and JALR always write register 31.
  - Every other class writes nothing and never causes a stall or a forward.
- R2: The decode instruction reads rs for ALU, ALUI, LOAD, STORE, BEQZ, BNEZ, JR and JALR. It reads rt only for ALU and STORE. A field that is not read never causes a stall.
- R3: With mode 0 (interlock only), stall is high when a read source matches the enabled destination of any older stage, and both selects are 0.
- R4: With mode 1 (execute bypass to operand A), sel_a is 1 when rs is read and matches the register written by an ALU or ALUI instruction in execute with a nonzero destination. Stall is high in two cases:
  - rs matches the destination of a LOAD (nonzero destination), JAL or JALR in execute, or the enabled destination in memory or writeback;
  - rt, when read, matches any enabled older destination.
  In this mode sel_b is always 0.
- R5: With mode 2 or 3 (full forwarding), stall is high only when a read source matches the nonzero rt of a LOAD in execute.
- R6: With mode 2 or 3, each operand select names the youngest older stage whose enabled destination matches that read source. The codes are 0 for the register file, 1 for execute, 2 for memory and 3 for writeback.
- R7: When execute holds BEQZ with ex_zero high, or BNEZ with ex_zero low, stall is low in every mode.
- R8: A select whose source is not read is 0. With NOP in all stages, stall and both selects are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode | input | 2 | 0 interlock only, 1 execute-to-A bypass, 2 or 3 full forwarding |
| id_op | input | 4 | Opcode class in decode |
| id_rs | input | 5 | First source field in decode |
| id_rt | input | 5 | Second source field in decode |
| ex_op | input | 4 | Opcode class in execute |
| ex_rt | input | 5 | rt field in execute |
| ex_rd | input | 5 | rd field in execute |
| ex_zero | input | 1 | Zero flag of the branch operand in execute |
| mem_op | input | 4 | Opcode class in memory |
| mem_rt | input | 5 | rt field in memory |
| mem_rd | input | 5 | rd field in memory |
| wb_op | input | 4 | Opcode class in writeback |
| wb_rt | input | 5 | rt field in writeback |
| wb_rd | input | 5 | rd field in writeback |
| stall | output | 1 | Hold decode and fetch and insert a bubble |
| sel_a | output | 2 | Forwarding source for operand A |
| sel_b | output | 2 | Forwarding source for operand B |

## Verification
The bench builds the block with the default register field width of 5. This makes register 31 the link register, which lets JAL and JALR destinations collide with ordinary rd and rt values. Random register fields are drawn from a small pool that includes 0 and 31. This makes same-register collisions between decode and several older stages frequent, so the youngest-match priority, the register-0 exclusion and the undefined opcode codes are reached in all mode settings. Directed tuples cover the two branch-kill polarities, loads with a zero destination and reads of unread fields.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  localparam int OPC_W = 4;
  localparam int SEL_W = 2;

  localparam logic [OPC_W-1:0] OP_NOP   = 4'd0;
  localparam logic [OPC_W-1:0] OP_ALU   = 4'd1;
  localparam logic [OPC_W-1:0] OP_ALUI  = 4'd2;
  localparam logic [OPC_W-1:0] OP_LOAD  = 4'd3;
  localparam logic [OPC_W-1:0] OP_STORE = 4'd4;
  localparam logic [OPC_W-1:0] OP_BEQZ  = 4'd5;
  localparam logic [OPC_W-1:0] OP_BNEZ  = 4'd6;
  localparam logic [OPC_W-1:0] OP_J     = 4'd7;
  localparam logic [OPC_W-1:0] OP_JAL   = 4'd8;
  localparam logic [OPC_W-1:0] OP_JR    = 4'd9;
  localparam logic [OPC_W-1:0] OP_JALR  = 4'd10;

  localparam logic [SEL_W-1:0] SRC_RF  = 2'd0;
  localparam logic [SEL_W-1:0] SRC_EX  = 2'd1;
  localparam logic [SEL_W-1:0] SRC_MEM = 2'd2;
  localparam logic [SEL_W-1:0] SRC_WB  = 2'd3;

  localparam int N_OLD = 3;
endpackage

// File: rtl/hazard_dest_dec.sv
module hazard_dest_dec
  import hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [OPC_W-1:0] op,
  input  logic [REG_W-1:0] rt,
  input  logic [REG_W-1:0] rd,
  output logic [REG_W-1:0] ws,
  output logic             we,
  output logic             we_byp,
  output logic             we_stl,
  output logic             is_load
);
  localparam logic [REG_W-1:0] LINK = {REG_W{1'b1}};

  always_comb begin
    ws      = '0;
    we      = 1'b0;
    we_byp  = 1'b0;
    we_stl  = 1'b0;
    is_load = 1'b0;
    case (op)
      OP_ALU: begin
        ws     = rd;
        we     = (rd != '0);
        we_byp = (rd != '0);
      end
      OP_ALUI: begin
        ws     = rt;
        we     = (rt != '0);
        we_byp = (rt != '0);
      end
      OP_LOAD: begin
        ws      = rt;
        we      = (rt != '0);
        we_stl  = (rt != '0);
        is_load = (rt != '0);
      end
      OP_JAL, OP_JALR: begin
        ws     = LINK;
        we     = 1'b1;
        we_stl = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/hazard_src_dec.sv
module hazard_src_dec
  import hazard_pkg::*;
(
  input  logic [OPC_W-1:0] op,
  output logic             re1,
  output logic             re2
);
  always_comb begin
    re1 = 1'b0;
    re2 = 1'b0;
    case (op)
      OP_ALU, OP_STORE: begin
        re1 = 1'b1;
        re2 = 1'b1;
      end
      OP_ALUI, OP_LOAD, OP_BEQZ, OP_BNEZ, OP_JR, OP_JALR: re1 = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/hazard_operand_ctl.sv
module hazard_operand_ctl
  import hazard_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter bit HAS_EX = 1'b1
) (
  input  logic [1:0]                  mode,
  input  logic [REG_W-1:0]            src,
  input  logic                        re,
  input  logic [N_OLD-1:0][REG_W-1:0] ws,
  input  logic [N_OLD-1:0]            we,
  input  logic                        ex_byp,
  input  logic                        ex_stl,
  input  logic                        ex_load,
  output logic [SEL_W-1:0]            sel,
  output logic                        hit
);
  logic [N_OLD-1:0] same;
  logic [N_OLD-1:0] live;

  genvar s;
  generate
    for (s = 0; s < N_OLD; s++) begin : g_cmp
      assign same[s] = re && (src == ws[s]);
      assign live[s] = same[s] && we[s];
    end
  endgenerate

  always_comb begin
    sel = SRC_RF;
    hit = 1'b0;
    if (mode[1]) begin
      if (live[0])      sel = SRC_EX;
      else if (live[1]) sel = SRC_MEM;
      else if (live[2]) sel = SRC_WB;
      hit = same[0] && ex_load;
    end else if (mode[0] && HAS_EX) begin
      if (same[0] && ex_byp) sel = SRC_EX;
      hit = (same[0] && ex_stl) || live[1] || live[2];
    end else begin
      hit = |live;
    end
  end
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [1:0]       mode,
  input  logic [OPC_W-1:0] id_op,
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] id_rt,
  input  logic [OPC_W-1:0] ex_op,
  input  logic [REG_W-1:0] ex_rt,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_zero,
  input  logic [OPC_W-1:0] mem_op,
  input  logic [REG_W-1:0] mem_rt,
  input  logic [REG_W-1:0] mem_rd,
  input  logic [OPC_W-1:0] wb_op,
  input  logic [REG_W-1:0] wb_rt,
  input  logic [REG_W-1:0] wb_rd,
  output logic             stall,
  output logic [SEL_W-1:0] sel_a,
  output logic [SEL_W-1:0] sel_b
);
  logic [N_OLD-1:0][OPC_W-1:0] st_op;
  logic [N_OLD-1:0][REG_W-1:0] st_rt, st_rd, st_ws;
  logic [N_OLD-1:0]            st_we, st_byp, st_stl, st_ld;
  logic                        re1, re2, hit_a, hit_b, br_taken;

  assign st_op = {wb_op, mem_op, ex_op};
  assign st_rt = {wb_rt, mem_rt, ex_rt};
  assign st_rd = {wb_rd, mem_rd, ex_rd};

  genvar s;
  generate
    for (s = 0; s < N_OLD; s++) begin : g_dest
      hazard_dest_dec #(.REG_W(REG_W)) u_dest (
        .op(st_op[s]), .rt(st_rt[s]), .rd(st_rd[s]),
        .ws(st_ws[s]), .we(st_we[s]), .we_byp(st_byp[s]),
        .we_stl(st_stl[s]), .is_load(st_ld[s])
      );
    end
  endgenerate

  hazard_src_dec u_src (.op(id_op), .re1(re1), .re2(re2));

  hazard_operand_ctl #(.REG_W(REG_W), .HAS_EX(1'b1)) u_opa (
    .mode(mode), .src(id_rs), .re(re1), .ws(st_ws), .we(st_we),
    .ex_byp(st_byp[0]), .ex_stl(st_stl[0]), .ex_load(st_ld[0]),
    .sel(sel_a), .hit(hit_a)
  );

  hazard_operand_ctl #(.REG_W(REG_W), .HAS_EX(1'b0)) u_opb (
    .mode(mode), .src(id_rt), .re(re2), .ws(st_ws), .we(st_we),
    .ex_byp(st_byp[0]), .ex_stl(st_stl[0]), .ex_load(st_ld[0]),
    .sel(sel_b), .hit(hit_b)
  );

  assign br_taken = ((ex_op == OP_BEQZ) && ex_zero) ||
                    ((ex_op == OP_BNEZ) && !ex_zero);
  assign stall = (hit_a || hit_b) && !br_taken;
endmodule

// File: rtl/hazard_ctrl_chk.sv
module hazard_ctrl_chk
  import hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input logic [1:0]       mode,
  input logic [OPC_W-1:0] id_op,
  input logic [REG_W-1:0] id_rs,
  input logic [REG_W-1:0] id_rt,
  input logic [OPC_W-1:0] ex_op,
  input logic             ex_zero,
  input logic             stall,
  input logic [SEL_W-1:0] sel_a,
  input logic [SEL_W-1:0] sel_b
);
  always_comb begin
    if (((ex_op == OP_BEQZ) && ex_zero) || ((ex_op == OP_BNEZ) && !ex_zero))
      AST_KILL_NO_STALL: assert (!stall);                              // R7
    if (mode == 2'd0)
      AST_INTERLOCK_NO_FWD: assert (sel_a == SRC_RF && sel_b == SRC_RF); // R3
    if (mode == 2'd1)
      AST_PARTIAL_B_RF: assert (sel_b == SRC_RF);                      // R4
    if (mode[1] && stall)
      AST_FULL_LOAD_ONLY: assert (ex_op == OP_LOAD);                   // R5
    if (id_op != OP_ALU && id_op != OP_STORE)
      AST_UNREAD_B_RF: assert (sel_b == SRC_RF);                       // R8
    if (id_rs == '0 && id_rt == '0)
      AST_ZERO_SRC_QUIET: assert (!stall && sel_a == SRC_RF && sel_b == SRC_RF); // R1
  end
endmodule

bind hazard_ctrl hazard_ctrl_chk #(.REG_W(REG_W)) u_chk (
  .mode(mode), .id_op(id_op), .id_rs(id_rs), .id_rt(id_rt),
  .ex_op(ex_op), .ex_zero(ex_zero), .stall(stall),
  .sel_a(sel_a), .sel_b(sel_b)
);

// File: tb/hazard_ctrl_bench.sv
`timescale 1ns/1ps
module hazard_ctrl_bench;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]    mode;
  logic [3:0]    id_op, ex_op, mem_op, wb_op;
  logic [RW-1:0] id_rs, id_rt, ex_rt, ex_rd, mem_rt, mem_rd, wb_rt, wb_rd;
  logic          ex_zero;
  logic          stall;
  logic [1:0]    sel_a, sel_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  hazard_ctrl #(.REG_W(RW)) u_hazard_ctrl (
    .mode(mode), .id_op(id_op), .id_rs(id_rs), .id_rt(id_rt),
    .ex_op(ex_op), .ex_rt(ex_rt), .ex_rd(ex_rd), .ex_zero(ex_zero),
    .mem_op(mem_op), .mem_rt(mem_rt), .mem_rd(mem_rd),
    .wb_op(wb_op), .wb_rt(wb_rt), .wb_rd(wb_rd),
    .stall(stall), .sel_a(sel_a), .sel_b(sel_b)
  );

  // written register of an older instruction: {enable, register}
  function automatic logic [RW:0] ref_dest(input logic [3:0] op,
                                           input logic [RW-1:0] rt,
                                           input logic [RW-1:0] rd);
    if (op == 4'd1) return {rd != 0, rd};
    if (op == 4'd2 || op == 4'd3) return {rt != 0, rt};
    if (op == 4'd8 || op == 4'd10) return {1'b1, 5'd31};
    return '0;
  endfunction

  function automatic bit ref_rd_rs(input logic [3:0] op);
    return op inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd9, 4'd10};
  endfunction

  function automatic bit ref_rd_rt(input logic [3:0] op);
    return op == 4'd1 || op == 4'd4;
  endfunction

  // {stall, sel_a, sel_b}
  function automatic logic [4:0] ref_out();
    logic [RW:0] de, dm, dw;
    logic [1:0]  sa, sb;
    bit ha, hb, ea, eb, ma, mb, wa, wb2, ra, rb, taken, exalu, exld;
    de = ref_dest(ex_op, ex_rt, ex_rd);
    dm = ref_dest(mem_op, mem_rt, mem_rd);
    dw = ref_dest(wb_op, wb_rt, wb_rd);
    ra = ref_rd_rs(id_op);
    rb = ref_rd_rt(id_op);
    ea = ra && de[RW] && de[RW-1:0] == id_rs;
    ma = ra && dm[RW] && dm[RW-1:0] == id_rs;
    wa = ra && dw[RW] && dw[RW-1:0] == id_rs;
    eb = rb && de[RW] && de[RW-1:0] == id_rt;
    mb = rb && dm[RW] && dm[RW-1:0] == id_rt;
    wb2 = rb && dw[RW] && dw[RW-1:0] == id_rt;
    exalu = ex_op == 4'd1 || ex_op == 4'd2;
    exld  = ex_op == 4'd3;
    sa = 0; sb = 0;
    if (mode == 2'd0) begin
      ha = ea || ma || wa; hb = eb || mb || wb2;
    end else if (mode == 2'd1) begin
      if (ea && exalu) sa = 1;
      ha = (ea && !exalu) || ma || wa;
      hb = eb || mb || wb2;
    end else begin
      sa = ea ? 2'd1 : ma ? 2'd2 : wa ? 2'd3 : 2'd0;
      sb = eb ? 2'd1 : mb ? 2'd2 : wb2 ? 2'd3 : 2'd0;
      ha = ea && exld; hb = eb && exld;
    end
    taken = (ex_op == 4'd5 && ex_zero) || (ex_op == 4'd6 && !ex_zero);
    return {(ha || hb) && !taken, sa, sb};
  endfunction

  task automatic apply(input logic [1:0] md, input logic [3:0] iop,
                       input logic [RW-1:0] irs, input logic [RW-1:0] irt,
                       input logic [3:0] eop, input logic [RW-1:0] ert,
                       input logic [RW-1:0] erd, input logic ez,
                       input logic [3:0] mop, input logic [RW-1:0] mrt,
                       input logic [RW-1:0] mrd, input logic [3:0] wop,
                       input logic [RW-1:0] wrt, input logic [RW-1:0] wrd);
    @(posedge clk);
    mode = md; id_op = iop; id_rs = irs; id_rt = irt;
    ex_op = eop; ex_rt = ert; ex_rd = erd; ex_zero = ez;
    mem_op = mop; mem_rt = mrt; mem_rd = mrd;
    wb_op = wop; wb_rt = wrt; wb_rd = wrd;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [4:0] exp);
    checks++;
    if ({stall, sel_a, sel_b} !== exp) begin
      errors++;
      $display("FAIL %s: stall/sel_a/sel_b actual %0b/%0d/%0d expected %0b/%0d/%0d",
               tag, stall, sel_a, sel_b, exp[4], exp[3:2], exp[1:0]);
    end
  endtask

  function automatic logic [RW-1:0] pick_reg();
    logic [2:0] k;
    k = 3'($urandom_range(0, 5));
    case (k)
      3'd0: return 5'd0;
      3'd1: return 5'd31;
      3'd2: return 5'd1;
      3'd3: return 5'd2;
      3'd4: return 5'd3;
      default: return 5'($urandom_range(0, 31));
    endcase
  endfunction

  initial begin
    #(8ns * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240917));
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 all nop", 5'b0_00_00);

    apply(0, 1, 1, 2, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    check("R3 interlock ex match", 5'b1_00_00);
    apply(1, 1, 1, 2, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    check("R4 ex alu to A", 5'b0_01_00);
    apply(1, 1, 4, 1, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    check("R4 rt match stalls", 5'b1_00_00);
    apply(1, 2, 31, 0, 8, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R4 jal in ex stalls", 5'b1_00_00);
    apply(2, 1, 1, 0, 3, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R5 load in ex stalls", 5'b1_01_00);
    apply(2, 1, 0, 0, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R1 load to r0", 5'b0_00_00);
    apply(3, 1, 5, 3, 0, 0, 0, 0, 1, 0, 3, 1, 0, 3);
    check("R6 mem over wb", 5'b0_00_10);
    apply(2, 2, 7, 0, 0, 0, 0, 0, 0, 0, 0, 3, 7, 0);
    check("R6 wb forward", 5'b0_11_00);
    apply(0, 1, 1, 0, 5, 0, 0, 1, 1, 0, 1, 0, 0, 0);
    check("R7 beqz taken", 5'b0_00_00);
    apply(0, 1, 1, 0, 5, 0, 0, 0, 1, 0, 1, 0, 0, 0);
    check("R7 beqz not taken", 5'b1_00_00);
    apply(0, 1, 1, 0, 6, 0, 0, 0, 1, 0, 1, 0, 0, 0);
    check("R7 bnez taken", 5'b0_00_00);
    apply(0, 7, 2, 2, 0, 0, 0, 0, 1, 0, 2, 0, 0, 0);
    check("R2 jump reads nothing", 5'b0_00_00);
    apply(0, 4, 0, 5, 0, 0, 0, 0, 0, 0, 0, 3, 5, 0);
    check("R2 store reads rt", 5'b1_00_00);
    apply(2, 2, 9, 9, 0, 0, 0, 0, 0, 0, 0, 1, 0, 9);
    check("R8 alui rt unread", 5'b0_11_00);
    apply(0, 2, 4, 0, 0, 0, 0, 0, 2, 4, 9, 0, 0, 0);
    check("R1 alui writes rt", 5'b1_00_00);
    apply(0, 2, 9, 0, 0, 0, 0, 0, 2, 4, 9, 0, 0, 0);
    check("R1 alui ignores rd", 5'b0_00_00);
    apply(2, 1, 3, 3, 12, 3, 3, 0, 0, 0, 0, 0, 0, 0);
    check("R1 undefined op", 5'b0_00_00);

    for (int i = 0; i < 4000; i++) begin
      apply(2'($urandom_range(0, 3)), 4'($urandom_range(0, 15)), pick_reg(), pick_reg(),
            4'($urandom_range(0, 15)), pick_reg(), pick_reg(), 1'($urandom_range(0, 1)),
            4'($urandom_range(0, 15)), pick_reg(), pick_reg(),
            4'($urandom_range(0, 15)), pick_reg(), pick_reg());
      case (mode)
        2'd0:    check("R3 random", ref_out());
        2'd1:    check("R4 random", ref_out());
        default: check("R6 random", ref_out());
      endcase
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule